// File: doc/BRIEF.md
# Core module control register bank

This block is the control and identity register bank of a processor core module. A host reaches it through a word-addressed request channel and a separate read-response channel. Through these it reads fixed identity and status words and programs two clock-oscillator words, which are guarded by a 16-bit unlock key. It also keeps two flag words with separate set and clear addresses, an SDRAM configuration word and an init word. A read-only window returns memory-module description bytes from an internal table, one byte per word. A small interrupt group holds one software-driven raw bit, an enable mask and a level output. A control address decides the boot-memory remap output.

The request channel uses valid/ready. A request moves when `req_valid` and `req_ready` are both high in the same cycle. A write takes effect on that edge and returns no response. An accepted read produces `rsp_valid` one cycle later. `rsp_data` then holds steady until `rsp_ready` is seen high. While a response waits, `req_ready` stays low, so a host that does not take responses stalls further requests. The memory-size parameter fixes the SDRAM size code and one table byte at reset. Addresses are byte offsets. Registers are chosen by the offset shifted right by two, and offsets of 0x200 or more are unmapped.

Top module: `cmb_bank`

## Requirements
- R1: `req_ready` is low exactly when `rsp_valid` is high and `rsp_ready` is low. An accepted read raises `rsp_valid` on the next cycle. `rsp_valid` and `rsp_data` then stay unchanged until a cycle where `rsp_ready` is high. Accepted writes take effect at the accepting edge and make no response.
- R2: Word 0 reads 0x411A3001. Word 4 reads 0x00100000. Words 1 and 3 read zero.
- R3: A write to word 5 keeps only wdata[15:0] as the key. A read of word 5 returns 0x0001A05F when the key equals 0xA05F, and the zero-extended key otherwise. The key resets to 0.
- R4: Word 2 (oscillator, reset 0x01000048) and word 7 (auxiliary oscillator, reset 0x0007FEFF) take a write only while the key equals 0xA05F. Otherwise the write leaves them unchanged.
- R5: Word 8 (SDRAM) resets to 0x00011122 ORed with a size code: 0x10 for MEM_MB of 256 or more, 0x0C for 128 or more, 0x08 for 64 or more, 0x04 for 32 or more, and 0 below that. Word 9 (init) resets to 0x00000112. Both take a full write and read back.
- R6: Writing word 12 ORs wdata into the flags, and writing word 13 clears the bits set in wdata. Words 14 and 15 do the same for the non-volatile flags. Flags read at word 12 and non-volatile flags read at word 14. Both reset to 0, and words 13 and 15 read zero.
- R7: Byte offsets 0x100 to 0x17F return table entry k = (offset-0x100)>>2, zero-extended. Entries 0 to 30 are 128,8,4,11,9,1,64,0,2,0xA0,0xA0,0,0,8,0,1,0x0E,4,0x1C,1,2,0x20,0xC0,0,0,0,0,0x30,0x28,0x30,0x28. Entry 31 is 64/32/16/4/2 for MEM_MB of at least 256/128/64/32 or below 32. Offsets 0x180 to 0x1FF read zero.
- R8: Word 18 ORs wdata into the enable mask, and word 19 clears the bits set in wdata. Word 20 sets raw bit 0 when wdata[0] is 1, and word 21 clears it when wdata[0] is 1. Reads return: word 16 raw AND enable, word 17 raw, word 18 enable, word 20 raw bit 0. `irq` is high exactly while raw AND enable is nonzero.
- R9: A write to word 3 flips `remap` when wdata[2] differs from init bit 2, and the init word becomes (init AND NOT 5) OR (wdata XOR 5). `remap` resets to 0.
- R10: Words 32 to 35, words 6, 10, 11, 19, 21, 22 to 31 and 36 to 63, and offsets of 0x200 or more read zero. Writes to them change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Host takes read data |
| rsp_data | output | 32 | Read data |
| irq | output | 1 | Enabled interrupt pending |
| remap | output | 1 | Boot-memory remap state |

## Verification
A corrupted register shows up on the first read of its word, which arrives one cycle after the read is accepted. So the bench reads back after each random write and compares against its own model, tested against the locked/unlocked key, the set/clear pairs and both halves of the table window. A wrong enable or raw bit shows on `irq` in the cycle after the write. A wrong remap decision shows on `remap` in that same cycle. A lost response shows as `rsp_valid` or `rsp_data` changing while the host holds `rsp_ready` low.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
  localparam logic [31:0] ID_WORD   = 32'h411A3001;
  localparam logic [31:0] STAT_WORD = 32'h00100000;
  localparam logic [15:0] UNLOCK    = 16'hA05F;
  localparam logic [31:0] OSC_RST   = 32'h01000048;
  localparam logic [31:0] AUX_RST   = 32'h0007FEFF;
  localparam logic [31:0] SDR_BASE  = 32'h00011122;
  localparam logic [31:0] INIT_RST  = 32'h00000112;

  localparam logic [6:0] W_ID    = 7'd0;
  localparam logic [6:0] W_PROC  = 7'd1;
  localparam logic [6:0] W_OSC   = 7'd2;
  localparam logic [6:0] W_CTRL  = 7'd3;
  localparam logic [6:0] W_STAT  = 7'd4;
  localparam logic [6:0] W_LOCK  = 7'd5;
  localparam logic [6:0] W_AUX   = 7'd7;
  localparam logic [6:0] W_SDR   = 7'd8;
  localparam logic [6:0] W_INIT  = 7'd9;
  localparam logic [6:0] W_FLS   = 7'd12;
  localparam logic [6:0] W_FLC   = 7'd13;
  localparam logic [6:0] W_NVS   = 7'd14;
  localparam logic [6:0] W_NVC   = 7'd15;
  localparam logic [6:0] W_IMSK  = 7'd16;
  localparam logic [6:0] W_IRAW  = 7'd17;
  localparam logic [6:0] W_IENS  = 7'd18;
  localparam logic [6:0] W_IENC  = 7'd19;
  localparam logic [6:0] W_SWS   = 7'd20;
  localparam logic [6:0] W_SWC   = 7'd21;

  function automatic logic [31:0] sdr_code(input int mb);
    if (mb >= 256)     return 32'h10;
    else if (mb >= 128) return 32'h0C;
    else if (mb >= 64)  return 32'h08;
    else if (mb >= 32)  return 32'h04;
    else                return 32'h00;
  endfunction

  function automatic logic [7:0] size_byte(input int mb);
    if (mb >= 256)     return 8'd64;
    else if (mb >= 128) return 8'd32;
    else if (mb >= 64)  return 8'd16;
    else if (mb >= 32)  return 8'd4;
    else                return 8'd2;
  endfunction
endpackage

// File: rtl/cmb_spd_rom.sv
module cmb_spd_rom
  import cmb_pkg::*;
#(
  parameter int MEM_MB = 128
) (
  input  logic [4:0] idx,
  output logic [7:0] dout
);
  localparam logic [7:0] LAST = size_byte(MEM_MB);

  always_comb begin
    case (idx)
      5'd0:  dout = 8'd128;
      5'd1:  dout = 8'd8;
      5'd2:  dout = 8'd4;
      5'd3:  dout = 8'd11;
      5'd4:  dout = 8'd9;
      5'd5:  dout = 8'd1;
      5'd6:  dout = 8'd64;
      5'd8:  dout = 8'd2;
      5'd9:  dout = 8'hA0;
      5'd10: dout = 8'hA0;
      5'd13: dout = 8'd8;
      5'd15: dout = 8'd1;
      5'd16: dout = 8'h0E;
      5'd17: dout = 8'd4;
      5'd18: dout = 8'h1C;
      5'd19: dout = 8'd1;
      5'd20: dout = 8'd2;
      5'd21: dout = 8'h20;
      5'd22: dout = 8'hC0;
      5'd27: dout = 8'h30;
      5'd28: dout = 8'h28;
      5'd29: dout = 8'h30;
      5'd30: dout = 8'h28;
      5'd31: dout = LAST;
      default: dout = 8'd0;
    endcase
  end
endmodule

// File: rtl/cmb_irq.sv
module cmb_irq
  import cmb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [6:0]    wr_word,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] enable,
  output logic          raw0,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable <= '0;
      raw0   <= 1'b0;
    end else if (wr_en) begin
      case (wr_word)
        W_IENS: enable <= enable | wdata;
        W_IENC: enable <= enable & ~wdata;
        W_SWS:  if (wdata[0]) raw0 <= 1'b1;
        W_SWC:  if (wdata[0]) raw0 <= 1'b0;
        default: ;
      endcase
    end
  end

  assign irq = raw0 & enable[0];

  assert_irq_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word == W_SWS && wdata[0] && enable[0]) |=> irq);
  assert_irq_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word == W_SWC && wdata[0]) |=> !irq);
endmodule

// File: rtl/cmb_regs.sv
module cmb_regs
  import cmb_pkg::*;
#(
  parameter int DW     = 32,
  parameter int MEM_MB = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [6:0]    wr_word,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] osc,
  output logic [DW-1:0] aux,
  output logic [15:0]   key,
  output logic [DW-1:0] sdram,
  output logic [DW-1:0] init,
  output logic [DW-1:0] flags,
  output logic [DW-1:0] nvflags,
  output logic          remap
);
  localparam logic [DW-1:0] SDR_RST  = DW'(SDR_BASE | sdr_code(MEM_MB));
  localparam logic [DW-1:0] CTL_MASK = DW'(5);

  logic unlocked;
  assign unlocked = (key == UNLOCK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      osc     <= DW'(OSC_RST);
      aux     <= DW'(AUX_RST);
      key     <= '0;
      sdram   <= SDR_RST;
      init    <= DW'(INIT_RST);
      flags   <= '0;
      nvflags <= '0;
      remap   <= 1'b0;
    end else if (wr_en) begin
      case (wr_word)
        W_OSC:  if (unlocked) osc <= wdata;
        W_AUX:  if (unlocked) aux <= wdata;
        W_LOCK: key <= wdata[15:0];
        W_SDR:  sdram <= wdata;
        W_INIT: init <= wdata;
        W_CTRL: begin
          if (init[2] != wdata[2]) remap <= ~remap;
          init <= (init & ~CTL_MASK) | (wdata ^ CTL_MASK);
        end
        W_FLS:  flags <= flags | wdata;
        W_FLC:  flags <= flags & ~wdata;
        W_NVS:  nvflags <= nvflags | wdata;
        W_NVC:  nvflags <= nvflags & ~wdata;
        default: ;
      endcase
    end
  end

  assert_lock_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_word == W_OSC || wr_word == W_AUX) && key != UNLOCK)
      |=> (osc == $past(osc) && aux == $past(aux)));
  assert_remap_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word == W_CTRL && (init[2] != wdata[2])) |=> remap != $past(remap));
  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word == W_FLC) |=> (flags & $past(wdata)) == '0);
endmodule

// File: rtl/cmb_bank.sv
module cmb_bank
  import cmb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int MEM_MB = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_data,
  output logic              irq,
  output logic              remap
);
  localparam int DW = 32;

  logic       in_range, accept, wr_en;
  logic [6:0] word;
  logic [1:0] unused_lsb;
  logic [DW-1:0] osc, aux, sdram, init, flags, nvflags, enable, rd_val;
  logic [15:0] key;
  logic raw0;
  logic [7:0] spd_byte;

  assign unused_lsb = req_addr[1:0];
  assign word      = req_addr[8:2];
  assign in_range  = (req_addr >> 9) == '0;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_en     = accept && req_write && in_range;

  cmb_regs #(.DW(DW), .MEM_MB(MEM_MB)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(word), .wdata(req_wdata),
    .osc(osc), .aux(aux), .key(key), .sdram(sdram), .init(init),
    .flags(flags), .nvflags(nvflags), .remap(remap)
  );

  cmb_irq #(.DW(DW)) u_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(word), .wdata(req_wdata),
    .enable(enable), .raw0(raw0), .irq(irq)
  );

  cmb_spd_rom #(.MEM_MB(MEM_MB)) u_spd (.idx(word[4:0]), .dout(spd_byte));

  always_comb begin
    rd_val = '0;
    if (in_range) begin
      if (word[6]) begin
        if (!word[5]) rd_val = {24'd0, spd_byte};
      end else begin
        case (word)
          W_ID:   rd_val = ID_WORD;
          W_OSC:  rd_val = osc;
          W_STAT: rd_val = STAT_WORD;
          W_LOCK: rd_val = (key == UNLOCK) ? 32'h0001A05F : {16'd0, key};
          W_AUX:  rd_val = aux;
          W_SDR:  rd_val = sdram;
          W_INIT: rd_val = init;
          W_FLS:  rd_val = flags;
          W_NVS:  rd_val = nvflags;
          W_IMSK: rd_val = {31'd0, raw0} & enable;
          W_IRAW: rd_val = {31'd0, raw0};
          W_IENS: rd_val = enable;
          W_SWS:  rd_val = {31'd0, raw0};
          default: rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_rsp_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write) |=> rsp_valid);
endmodule

// File: tb/cmb_bank_bench.sv
module cmb_bank_bench;
  localparam int ADDR_W = 12;
  localparam int MEM_MB = 128;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, irq, remap;
  logic [31:0] rsp_data;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  cmb_bank #(.ADDR_W(ADDR_W), .MEM_MB(MEM_MB)) u_cmb_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .irq(irq), .remap(remap)
  );

  // model
  logic [31:0] m_osc, m_aux, m_sdram, m_init, m_flags, m_nv, m_en;
  logic [15:0] m_key;
  logic m_raw, m_remap;

  task automatic model_reset();
    m_osc = 32'h01000048; m_aux = 32'h0007FEFF; m_key = 0;
    m_sdram = 32'h00011122 | 32'h0C; m_init = 32'h112;
    m_flags = 0; m_nv = 0; m_en = 0; m_raw = 0; m_remap = 0;
  endtask

  function automatic logic [7:0] spd_exp(input int k);
    byte unsigned t[31] = '{128,8,4,11,9,1,64,0,2,8'hA0,8'hA0,0,0,8,0,1,
                            8'h0E,4,8'h1C,1,2,8'h20,8'hC0,0,0,0,0,8'h30,8'h28,8'h30,8'h28};
    if (k == 31) return 8'd32;
    return t[k];
  endfunction

  function automatic logic [31:0] exp_read(input logic [ADDR_W-1:0] a);
    int w;
    w = int'(a >> 2);
    if (a >= 12'h200) return 0;
    if (w >= 64) return (w < 96) ? {24'd0, spd_exp(w - 64)} : 32'd0;
    case (w)
      0: return 32'h411A3001;
      2: return m_osc;
      4: return 32'h00100000;
      5: return (m_key == 16'hA05F) ? 32'h1A05F : {16'd0, m_key};
      7: return m_aux;
      8: return m_sdram;
      9: return m_init;
      12: return m_flags;
      14: return m_nv;
      16: return {31'd0, m_raw} & m_en;
      17: return {31'd0, m_raw};
      18: return m_en;
      20: return {31'd0, m_raw};
      default: return 0;
    endcase
  endfunction

  task automatic model_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    int w;
    w = int'(a >> 2);
    if (a >= 12'h200) return;
    case (w)
      2: if (m_key == 16'hA05F) m_osc = d;
      3: begin
        if (m_init[2] != d[2]) m_remap = ~m_remap;
        m_init = (m_init & ~32'd5) | (d ^ 32'd5);
      end
      5: m_key = d[15:0];
      7: if (m_key == 16'hA05F) m_aux = d;
      8: m_sdram = d;
      9: m_init = d;
      12: m_flags = m_flags | d;
      13: m_flags = m_flags & ~d;
      14: m_nv = m_nv | d;
      15: m_nv = m_nv & ~d;
      18: m_en = m_en | d;
      19: m_en = m_en & ~d;
      20: if (d[0]) m_raw = 1;
      21: if (d[0]) m_raw = 0;
      default: ;
    endcase
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk);
    model_write(a, d);
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    d = rsp_data;
  endtask

  task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp_read(a));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [ADDR_W-1:0] pick [24] = '{12'h000,12'h004,12'h008,12'h00C,12'h010,12'h014,12'h01C,
    12'h020,12'h024,12'h030,12'h034,12'h038,12'h03C,12'h040,12'h044,12'h048,12'h04C,
    12'h050,12'h054,12'h080,12'h018,12'h100,12'h17C,12'h180};

  initial begin : main
    logic [31:0] d, hold;
    void'($urandom(32'h5EED));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    check("R1 reset rsp_valid", {31'd0, rsp_valid}, 0);
    check("R9 reset remap", {31'd0, remap}, 0);
    check("R8 reset irq", {31'd0, irq}, 0);
    rd_chk("R2 id", 12'h000);
    rd_chk("R2 status", 12'h010);
    rd_chk("R2 proc", 12'h004);
    rd_chk("R4 osc reset", 12'h008);
    rd_chk("R4 aux reset", 12'h01C);
    rd_chk("R5 sdram reset", 12'h020);
    rd_chk("R5 init reset", 12'h024);
    rd_chk("R3 key reset", 12'h014);
    // lock gating
    wr(12'h008, 32'hDEADBEEF);
    rd_chk("R4 osc locked", 12'h008);
    wr(12'h014, 32'hFFFFA05F);
    rd_chk("R3 key unlocked read", 12'h014);
    wr(12'h008, 32'h12345678);
    rd_chk("R4 osc unlocked", 12'h008);
    wr(12'h01C, 32'h0BADF00D);
    rd_chk("R4 aux unlocked", 12'h01C);
    wr(12'h014, 32'h1234);
    rd_chk("R3 key other", 12'h014);
    wr(12'h01C, 32'h1);
    rd_chk("R4 aux relocked", 12'h01C);
    // flags
    wr(12'h030, 32'h0000_00F0); wr(12'h034, 32'h0000_0030);
    rd_chk("R6 flags set/clear", 12'h030);
    rd_chk("R6 clear word reads zero", 12'h034);
    wr(12'h038, 32'hA5A5_0000); wr(12'h03C, 32'h0505_0000);
    rd_chk("R6 nvflags", 12'h038);
    // spd window bounds
    rd_chk("R7 spd first", 12'h100);
    rd_chk("R7 spd size byte", 12'h17C);
    rd_chk("R7 spd entry 9", 12'h124);
    rd_chk("R7 upper half zero", 12'h180);
    rd_chk("R7 end zero", 12'h1FC);
    // voltage / unmapped
    wr(12'h080, 32'hFFFFFFFF);
    rd_chk("R10 voltage", 12'h080);
    rd_chk("R10 beyond 0x200", 12'h204);
    // interrupts
    wr(12'h050, 32'h1);
    check("R8 irq masked", {31'd0, irq}, 0);
    wr(12'h048, 32'h1);
    check("R8 irq on", {31'd0, irq}, 1);
    rd_chk("R8 masked status", 12'h040);
    wr(12'h04C, 32'h1);
    check("R8 irq disabled", {31'd0, irq}, 0);
    // remap
    wr(12'h00C, 32'h4);
    check("R9 remap flip", {31'd0, remap}, {31'd0, m_remap});
    rd_chk("R9 init after ctrl", 12'h024);
    // back-pressure
    @(negedge clk); rsp_ready = 0; req_valid = 1; req_write = 0; req_addr = 12'h000;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    hold = rsp_data;
    check("R1 rsp valid", {31'd0, rsp_valid}, 1);
    check("R1 ready low", {31'd0, req_ready}, 0);
    repeat (2) @(negedge clk);
    check("R1 data held", rsp_data, hold);
    check("R1 valid held", {31'd0, rsp_valid}, 1);
    rsp_ready = 1;
    @(negedge clk);
    check("R1 drained", {31'd0, rsp_valid}, 0);
    // random
    for (int i = 0; i < 600; i++) begin
      logic [ADDR_W-1:0] a;
      a = pick[$urandom_range(0, 23)];
      if ($urandom_range(0, 1) == 1) begin
        d = $urandom();
        if ($urandom_range(0, 3) == 0) d = 32'h0000A05F;
        wr(a, d);
        check("R8 R9 outputs", {30'd0, irq, remap}, {30'd0, m_raw & m_en[0], m_remap});
      end else begin
        rd_chk("R3 R4 R5 R6 R8 random read", a);
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule